// File: doc/BRIEF.md
# Four-State Power Mode Controller

This block sets the operating mode of a device to one of four levels: Active, Power Save, Idle and Halt. From that mode it drives the choice of core clock (fast or slow) and a gate enable for each of four clock domains. The domains are the core, a group of modules that can run on the slow clock, a group of modules that run only on the fast clock, and an always-on group that holds the power logic and the timer/watchdog logic. Software asks for a low-power mode with a one-cycle request. Sixteen wake-up inputs can bring the device back. One of these inputs is normally the periodic real-time tick.

Each wake-up input sets a sticky pending bit. Software clears these bits with write-one-to-clear strobes. A mask picks which pending bits count as wake events. An enabled wake event blocks entry into a low-power mode and forces exit from one. On exit the core first runs on the slow clock while a settle count runs down. Only then does the fast clock return.

The states are ST_ACTIVE, ST_PSAVE, ST_IDLE, ST_HALT and ST_SETTLE. The transitions are as follows. An accepted request moves ST_ACTIVE to a low-power state. An enabled wake moves any low-power state to ST_SETTLE. When the settle count expires, ST_SETTLE returns to ST_ACTIVE.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode is Active (mode_status 00), every clock enable is high, core_fast_sel is high and wake_pending is all zero.
- R2: The outputs follow the mode. Active: fast select 1, core 1, slow group 1, fast group 1, always-on 1. Power Save: fast select 0, core 1, slow group 1, fast group 0, always-on 1. Idle: only always-on is 1. Halt: every enable and the fast select are 0.
- R3: In Active, a request with mode_req 01 (Power Save), 10 (Idle) or 11 (Halt) changes mode_status to that code one cycle later.
- R4: A request in Active is refused, and the mode stays Active, when mode_req is 00 or when any bit of (wake_pending OR wake_in) AND wake_mask is set in the request cycle.
- R5: wake_in bit i sets wake_pending bit i in the next cycle whatever the mask. The bit stays set until pend_clr bit i is high, and a set wins over a clear in the same cycle.
- R6: In Power Save, Idle or Halt, an enabled wake (pending or arriving) moves the block to settling in the next cycle. Masked wakes leave the mode unchanged.
- R7: Settling lasts stab_count+1 cycles, shows mode_status 01 with Power Save clock enables, ignores requests and wakes, and then returns to Active.
- R8: A mode request made outside Active has no effect on the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_req_valid | input | 1 | One-cycle software mode request strobe |
| mode_req | input | 2 | Requested mode code |
| wake_in | input | NUM_WAKE | Wake-up event inputs |
| wake_mask | input | NUM_WAKE | Wake-up enable mask |
| pend_clr | input | NUM_WAKE | Write-one-to-clear for pending bits |
| stab_count | input | STAB_W | Settle cycles before the fast clock returns |
| mode_status | output | 2 | Current mode code |
| core_fast_sel | output | 1 | 1 selects the fast clock for the core |
| core_clk_en | output | 1 | Core clock gate enable |
| slow_grp_clk_en | output | 1 | Slow-capable module group enable |
| fast_grp_clk_en | output | 1 | Fast-only module group enable |
| aon_clk_en | output | 1 | Always-on group (power and timer/watchdog) enable |
| wake_pending | output | NUM_WAKE | Sticky wake pending bits |

## Verification
Two pairs of events can land in the same cycle. In the first, a low-power request arrives in the cycle an enabled wake-up rises. The bench drives both on one edge, and the reference model expects the request to be refused, the mode to stay Active and the pending bit to be set. In the second, one pending bit gets a set and a clear together. The model expects the bit to stay set. A behavioural model runs beside the design and is compared with every output on every clock.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    typedef enum logic [2:0] {
        ST_ACTIVE = 3'd0,
        ST_PSAVE  = 3'd1,
        ST_IDLE   = 3'd2,
        ST_HALT   = 3'd3,
        ST_SETTLE = 3'd4
    } pmc_state_e;

    localparam logic [1:0] MODE_ACTIVE = 2'b00;
    localparam logic [1:0] MODE_PSAVE  = 2'b01;
    localparam logic [1:0] MODE_IDLE   = 2'b10;
    localparam logic [1:0] MODE_HALT   = 2'b11;

    typedef struct packed {
        logic fast_sel;
        logic core_en;
        logic slow_grp_en;
        logic fast_grp_en;
        logic aon_en;
    } clk_pol_t;
endpackage

// File: rtl/pmc_wake_latch.sv
module pmc_wake_latch #(
    parameter int NUM_WAKE = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_WAKE-1:0] wake_in,
    input  logic [NUM_WAKE-1:0] wake_mask,
    input  logic [NUM_WAKE-1:0] pend_clr,
    output logic [NUM_WAKE-1:0] pend_q,
    output logic                wake_hit
);
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~pend_clr) | wake_in;
    end

    assign wake_hit = |((pend_q | wake_in) & wake_mask);

    // R5
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_in != '0) |=> ((pend_q & $past(wake_in)) == $past(wake_in)));

    // R5
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr == '0) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

// File: rtl/pmc_settle_timer.sv
module pmc_settle_timer #(
    parameter int STAB_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [STAB_W-1:0] init,
    output logic              zero
);
    logic [STAB_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= init;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R7
    settle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pmc_clk_policy.sv
module pmc_clk_policy
    import pmc_pkg::*;
(
    input  pmc_state_e state,
    output clk_pol_t   pol,
    output logic [1:0] mode_code
);
    always_comb begin
        unique case (state)
            ST_ACTIVE: begin pol = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1}; mode_code = MODE_ACTIVE; end
            ST_PSAVE:  begin pol = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1}; mode_code = MODE_PSAVE;  end
            ST_IDLE:   begin pol = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1}; mode_code = MODE_IDLE;   end
            ST_HALT:   begin pol = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0}; mode_code = MODE_HALT;   end
            ST_SETTLE: begin pol = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1}; mode_code = MODE_PSAVE;  end
            default:   begin pol = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1}; mode_code = MODE_ACTIVE; end
        endcase
    end

    // R2
    fast_implies_all_chk: assert final (!pol.fast_sel || (pol.core_en && pol.slow_grp_en && pol.fast_grp_en && pol.aon_en));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int NUM_WAKE = 16,
    parameter int STAB_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_req_valid,
    input  logic [1:0]          mode_req,
    input  logic [NUM_WAKE-1:0] wake_in,
    input  logic [NUM_WAKE-1:0] wake_mask,
    input  logic [NUM_WAKE-1:0] pend_clr,
    input  logic [STAB_W-1:0]   stab_count,
    output logic [1:0]          mode_status,
    output logic                core_fast_sel,
    output logic                core_clk_en,
    output logic                slow_grp_clk_en,
    output logic                fast_grp_clk_en,
    output logic                aon_clk_en,
    output logic [NUM_WAKE-1:0] wake_pending
);
    pmc_state_e state_q, state_d;
    logic       wake_hit;
    logic       timer_zero;
    logic       low_power;
    logic       settle_load;
    clk_pol_t   pol;

    pmc_wake_latch #(.NUM_WAKE(NUM_WAKE)) u_wake (
        .clk(clk), .rst_n(rst_n), .wake_in(wake_in), .wake_mask(wake_mask),
        .pend_clr(pend_clr), .pend_q(wake_pending), .wake_hit(wake_hit)
    );

    assign low_power   = (state_q == ST_PSAVE) || (state_q == ST_IDLE) || (state_q == ST_HALT);
    assign settle_load = low_power && wake_hit;

    pmc_settle_timer #(.STAB_W(STAB_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(settle_load), .init(stab_count), .zero(timer_zero)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ACTIVE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE: begin
                if (mode_req_valid && !wake_hit) begin
                    unique case (mode_req)
                        MODE_PSAVE: state_d = ST_PSAVE;
                        MODE_IDLE:  state_d = ST_IDLE;
                        MODE_HALT:  state_d = ST_HALT;
                        default:    state_d = ST_ACTIVE;
                    endcase
                end
            end
            ST_PSAVE, ST_IDLE, ST_HALT: begin
                if (wake_hit) state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (timer_zero) state_d = ST_ACTIVE;
            end
            default: state_d = ST_ACTIVE;
        endcase
    end

    pmc_clk_policy u_policy (.state(state_q), .pol(pol), .mode_code(mode_status));

    assign core_fast_sel   = pol.fast_sel;
    assign core_clk_en     = pol.core_en;
    assign slow_grp_clk_en = pol.slow_grp_en;
    assign fast_grp_clk_en = pol.fast_grp_en;
    assign aon_clk_en      = pol.aon_en;

    // R4
    refuse_on_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && wake_hit) |=> (state_q == ST_ACTIVE));

    // R6
    exit_on_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (low_power && wake_hit) |=> (state_q == ST_SETTLE));

    // R7
    settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE && !timer_zero) |=> (state_q == ST_SETTLE));

    // R8
    no_req_outside_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_ACTIVE && !wake_hit && state_q != ST_SETTLE) |=> $stable(state_q));
endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
    localparam int N = 16;
    localparam int W = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_v = 1'b0;
    logic [1:0]    req = 2'b00;
    logic [N-1:0]  wake = '0;
    logic [N-1:0]  mask = '0;
    logic [N-1:0]  clr = '0;
    logic [W-1:0]  stab = '0;
    logic [1:0]    st;
    logic          fsel, cen, sgen, fgen, aen;
    logic [N-1:0]  pend;

    int            vectors = 0;
    int            errors = 0;
    int            cycles = 0;
    bit            finished = 1'b0;

    int            m_mode;
    logic [N-1:0]  m_pend;
    int            m_cnt;

    always #5 clk = ~clk;

    pwr_mode_ctrl #(.NUM_WAKE(N), .STAB_W(W)) u_pwr_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_req_valid(req_v), .mode_req(req),
        .wake_in(wake), .wake_mask(mask), .pend_clr(clr), .stab_count(stab),
        .mode_status(st), .core_fast_sel(fsel), .core_clk_en(cen),
        .slow_grp_clk_en(sgen), .fast_grp_clk_en(fgen), .aon_clk_en(aen),
        .wake_pending(pend)
    );

    task automatic compare(input string tag);
        logic [1:0] e_st;
        logic [4:0] e_en;
        logic [4:0] a_en;
        bit bad = 1'b0;
        case (m_mode)
            0: begin e_st = 2'b00; e_en = 5'b11111; end
            1: begin e_st = 2'b01; e_en = 5'b01101; end
            2: begin e_st = 2'b10; e_en = 5'b00001; end
            3: begin e_st = 2'b11; e_en = 5'b00000; end
            default: begin e_st = 2'b01; e_en = 5'b01101; end
        endcase
        a_en = {fsel, cen, sgen, fgen, aen};
        vectors++;
        if (st !== e_st) begin
            $display("FAIL %s mode_status actual %b expected %b", tag, st, e_st); bad = 1'b1;
        end
        if (a_en !== e_en) begin
            $display("FAIL %s enables actual %b expected %b", tag, a_en, e_en); bad = 1'b1;
        end
        if (pend !== m_pend) begin
            $display("FAIL %s wake_pending actual %h expected %h", tag, pend, m_pend); bad = 1'b1;
        end
        if (bad) errors++;
    endtask

    task automatic cyc(input logic rv, input logic [1:0] rq, input logic [N-1:0] w,
                       input logic [N-1:0] c, input string tag);
        int n_mode;
        int n_cnt;
        bit hit;
        req_v = rv; req = rq; wake = w; clr = c;
        hit = |((m_pend | w) & mask);
        n_mode = m_mode;
        n_cnt = m_cnt;
        case (m_mode)
            0: if (rv && rq != 2'b00 && !hit) n_mode = int'(rq);
            1, 2, 3: if (hit) begin n_mode = 4; n_cnt = int'(stab); end
            default: if (m_cnt == 0) n_mode = 0; else n_cnt = m_cnt - 1;
        endcase
        @(posedge clk);
        @(negedge clk);
        m_mode = n_mode;
        m_cnt = n_cnt;
        m_pend = (m_pend & ~c) | w;
        compare(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 2'b00, '0, '0, tag);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            $display("FAIL watchdog expired actual %0d cycles expected fewer", cycles);
            errors++;
            finish_run();
        end
    end

    initial begin
        m_mode = 0; m_pend = '0; m_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1");
        idle(2, "R1");

        mask = 16'h0001; stab = 8'd3;
        cyc(1'b1, 2'b00, '0, '0, "R4");          // code 00 refused
        cyc(1'b1, 2'b01, '0, '0, "R3");          // to Power Save
        idle(1, "R2");
        cyc(1'b1, 2'b10, '0, '0, "R8");          // request outside Active
        idle(1, "R8");
        cyc(1'b0, 2'b00, 16'h0002, '0, "R6");    // masked wake, stays
        idle(1, "R5");
        cyc(1'b0, 2'b00, 16'h0001, '0, "R6");    // enabled wake -> settle
        cyc(1'b1, 2'b11, 16'h0004, '0, "R7");    // ignored while settling
        idle(4, "R7");                           // back to Active

        cyc(1'b1, 2'b10, '0, '0, "R4");          // pending bit0 blocks entry
        cyc(1'b0, 2'b00, '0, 16'h0001, "R5");    // clear bit0
        cyc(1'b1, 2'b10, '0, '0, "R3");          // to Idle
        idle(1, "R2");

        mask = 16'h8000; stab = 8'd0;
        cyc(1'b0, 2'b00, 16'h0001, '0, "R6");    // masked now
        cyc(1'b0, 2'b00, 16'h8000, '0, "R6");    // exit
        idle(2, "R7");
        cyc(1'b0, 2'b00, '0, 16'hFFFF, "R5");

        cyc(1'b1, 2'b11, 16'h8000, '0, "R4");    // collision: refused
        cyc(1'b0, 2'b00, 16'h8000, 16'h8000, "R5"); // set beats clear
        cyc(1'b0, 2'b00, '0, 16'h8000, "R5");
        cyc(1'b1, 2'b11, '0, '0, "R3");          // to Halt
        idle(2, "R2");
        cyc(1'b0, 2'b00, 16'h8000, '0, "R6");
        idle(3, "R7");
        finish_run();
    end
endmodule